// File: doc/BRIEF.md
# Receive Guard Time and Bit-Grid Aligner

This block decides when a contactless reader's receive path may start listening after the reader has finished sending a frame, and where each correlation window sits in time. It runs on the carrier clock. When the transmit side reports that a frame has ended, the block waits a programmable number of whole bit periods. This wait is the frame guard time, during which a card is not allowed to answer. After the wait it raises the receiver enable.

While the receiver is enabled, the block produces two single-cycle strobes. One marks the start of each bit window and the other marks the middle of it. Both are placed relative to the transmit bit grid, shifted by a programmable number of carrier periods. This lets the correlator line its integration intervals up with the card's response. A new transmission drops the receiver at once.

The grid runs at 128 carrier cycles per bit. It is anchored to the clock edge that samples the end of the frame.

Top module: `rx_window_timer`

## Requirements
- R1: After reset, `rxEnable`, `bitStrobe` and `halfStrobe` are low, and `rxEnable` stays low until a `txEnd` pulse is sampled.
- R2: If the sampled guard value G is non-zero, `rxEnable` is low for the first 128·G−1 cycles after the edge that samples `txEnd`, and it goes high at edge 128·G after that edge.
- R3: If the sampled guard value is 0, `rxEnable` is high from the very edge that samples `txEnd`.
- R4: A sampled `txStart` drives `rxEnable` and both strobes low from that edge onward and stops all counting. `txStart` takes priority over a `txEnd` sampled on the same edge.
- R5: Both strobes stay low whenever `rxEnable` is low, and in particular throughout the guard time.
- R6: The grid phase is the number of edges since the `txEnd` edge, taken modulo 128. While enabled, `bitStrobe` is high exactly in the cycles where the grid phase equals the latched offset, so it repeats every 128 cycles.
- R7: While enabled, `halfStrobe` is high exactly when the grid phase equals (offset + 64) mod 128. It is never high together with `bitStrobe`.
- R8: An offset of 128 or more acts as its value modulo 128. For example, 200 behaves as 72.
- R9: The guard value and the offset are captured on the `txEnd` edge. Changing `guardBits` or `phaseOffset` afterwards has no effect until the next `txEnd`.
- R10: A `txEnd` sampled during a guard wait or while receiving restarts the guard time and the grid from zero, using the newly sampled settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txStart | input | 1 | One-cycle pulse: a transmission begins |
| txEnd | input | 1 | One-cycle pulse: a transmission has ended |
| guardBits | input | 8 | Guard time in bit periods |
| phaseOffset | input | 8 | Window offset in carrier cycles (modulo 128) |
| rxEnable | output | 1 | Receiver may listen |
| bitStrobe | output | 1 | Start of a correlation bit window |
| halfStrobe | output | 1 | Middle of a correlation bit window |

## Verification
The bench targets the exact edge at which the receiver turns on. An off-by-one guard counter would raise `rxEnable` one cycle early or late. A zero guard handled as 256 bit periods would leave the receiver dark for a long time.

Offsets above 127 are used to catch designs that do not wrap the value and therefore never fire, or fire at the wrong phase. Settings are changed right after `txEnd` to catch designs that read the inputs live. `txStart` is exercised during the guard, during reception, and on the same edge as `txEnd`, to expose a receiver left on or a grid that keeps running.

// File: rtl/rxwin_pkg.sv
package rxwin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TX     = 2'd1,
    ST_GUARD  = 2'd2,
    ST_LISTEN = 2'd3
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic loadCfg;
    logic runGrid;
  } gridCtrl_t;

endpackage

// File: rtl/rxwin_ctrl.sv
module rxwin_ctrl
  import rxwin_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txStart,
  input  logic      txEnd,
  input  logic      guardIsZero,
  input  logic      guardDone,
  output gridCtrl_t ctrl,
  output logic      rxEnable
);

  rxState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (txStart)                               stateNext = ST_TX;
    else if (txEnd)                            stateNext = guardIsZero ? ST_LISTEN : ST_GUARD;
    else if (state == ST_GUARD && guardDone)   stateNext = ST_LISTEN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctrl.clearAll = txStart;
    ctrl.loadCfg  = txEnd && !txStart;
    ctrl.runGrid  = !txStart && !txEnd &&
                    (state == ST_GUARD || state == ST_LISTEN);
  end

  assign rxEnable = (state == ST_LISTEN);

  // R4: a transmission start silences the receiver on the next cycle
  p_start_kills_r4: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !rxEnable);

  // R3: zero guard opens the receiver right after the end edge
  p_zero_guard_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txEnd && !txStart && guardIsZero) |=> rxEnable);

  // R2: receiver stays closed while the guard has not run out
  p_guard_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GUARD && !guardDone && !txStart && !txEnd) |=> !rxEnable);

endmodule

// File: rtl/rxwin_grid.sv
module rxwin_grid
  import rxwin_pkg::*;
#(
  parameter int BIT_CYCLES = 128,
  parameter int GUARD_W    = 8,
  parameter int PHASE_W    = 8,
  parameter int NUM_TAPS   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  gridCtrl_t          ctrl,
  input  logic [GUARD_W-1:0] guardBits,
  input  logic [PHASE_W-1:0] phaseOffset,
  input  logic               rxEnable,
  output logic               guardIsZero,
  output logic               guardDone,
  output logic [NUM_TAPS-1:0] tapStrobe
);

  localparam int PH_W     = $clog2(BIT_CYCLES);
  localparam int TAP_STEP = BIT_CYCLES / NUM_TAPS;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CYCLES - 1);

  logic [PH_W-1:0]    gridPh;
  logic [GUARD_W-1:0] bitsLeft;
  logic [PH_W-1:0]    offQ;
  logic [PHASE_W+PH_W-1:0] offExt;

  assign offExt      = {{PH_W{1'b0}}, phaseOffset};
  assign guardIsZero = (guardBits == '0);
  assign guardDone   = (bitsLeft == GUARD_W'(1)) && (gridPh == PH_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gridPh   <= '0;
      bitsLeft <= '0;
      offQ     <= '0;
    end else if (ctrl.clearAll) begin
      gridPh   <= '0;
      bitsLeft <= '0;
      offQ     <= '0;
    end else if (ctrl.loadCfg) begin
      gridPh   <= '0;
      bitsLeft <= guardBits;
      offQ     <= offExt[PH_W-1:0];   // modulo one bit period
    end else if (ctrl.runGrid) begin
      gridPh <= gridPh + 1'b1;
      if (gridPh == PH_LAST && bitsLeft != '0)
        bitsLeft <= bitsLeft - 1'b1;
    end
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    logic [PH_W-1:0] tapPos;
    assign tapPos       = offQ + PH_W'(t * TAP_STEP);
    assign tapStrobe[t] = rxEnable && (gridPh == tapPos);
  end

  // R9: settings are captured on the end edge
  p_load_cfg_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadCfg |=> (gridPh == '0 && bitsLeft == $past(guardBits)));

  // R5: no strobe without an open receiver
  p_strobe_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tapStrobe != '0) |-> rxEnable);

  // R7: the taps never coincide
  p_taps_apart_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tapStrobe));

endmodule

// File: rtl/rx_window_timer.sv
module rx_window_timer
  import rxwin_pkg::*;
#(
  parameter int BIT_CYCLES = 128,
  parameter int GUARD_W    = 8,
  parameter int PHASE_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txStart,
  input  logic               txEnd,
  input  logic [GUARD_W-1:0] guardBits,
  input  logic [PHASE_W-1:0] phaseOffset,
  output logic               rxEnable,
  output logic               bitStrobe,
  output logic               halfStrobe
);

  localparam int NUM_TAPS = 2;

  gridCtrl_t           ctrl;
  logic                guardIsZero;
  logic                guardDone;
  logic [NUM_TAPS-1:0] tapStrobe;

  rxwin_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txStart    (txStart),
    .txEnd      (txEnd),
    .guardIsZero(guardIsZero),
    .guardDone  (guardDone),
    .ctrl       (ctrl),
    .rxEnable   (rxEnable)
  );

  rxwin_grid #(
    .BIT_CYCLES(BIT_CYCLES),
    .GUARD_W   (GUARD_W),
    .PHASE_W   (PHASE_W),
    .NUM_TAPS  (NUM_TAPS)
  ) u_grid (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .guardBits  (guardBits),
    .phaseOffset(phaseOffset),
    .rxEnable   (rxEnable),
    .guardIsZero(guardIsZero),
    .guardDone  (guardDone),
    .tapStrobe  (tapStrobe)
  );

  assign bitStrobe  = tapStrobe[0];
  assign halfStrobe = tapStrobe[1];

  // R6: a bit strobe is not repeated on the following cycle
  p_bit_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && !txStart && !txEnd) |=> !bitStrobe);

endmodule

// File: tb/rx_window_timer_tb_top.sv
`timescale 1ns/1ps
module rx_window_timer_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txStart = 1'b0;
  logic       txEnd = 1'b0;
  logic [7:0] guardBits = 8'd0;
  logic [7:0] phaseOffset = 8'd0;
  logic       rxEnable, bitStrobe, halfStrobe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rx_window_timer dut_i (
    .clk(clk), .rstN(rstN), .txStart(txStart), .txEnd(txEnd),
    .guardBits(guardBits), .phaseOffset(phaseOffset),
    .rxEnable(rxEnable), .bitStrobe(bitStrobe), .halfStrobe(halfStrobe)
  );

  // behavioural reference
  int  mPh = 0, mOff = 0, mGuard = 0, mElapsed = 0;
  bit  mEn = 0, mRun = 0, mCounting = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rstN) begin
      mPh = 0; mOff = 0; mEn = 0; mRun = 0; mCounting = 0;
    end else if (txStart) begin
      mPh = 0; mOff = 0; mEn = 0; mRun = 0; mCounting = 0;
    end else if (txEnd) begin
      mOff = int'(phaseOffset) % 128;
      mPh = 0; mElapsed = 0; mGuard = int'(guardBits);
      mEn = (guardBits == 0); mCounting = (guardBits != 0); mRun = 1;
    end else if (mRun) begin
      mPh = (mPh + 1) % 128;
      if (mCounting) begin
        mElapsed = mElapsed + 1;
        if (mElapsed == mGuard * 128) begin mEn = 1; mCounting = 0; end
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2/R3 model rxEnable", rxEnable, mEn);
      chk("R5/R6 model bitStrobe", bitStrobe, mEn && mPh == mOff);
      chk("R5/R7 model halfStrobe", halfStrobe, mEn && mPh == (mOff + 64) % 128);
    end
  end

  // leaves the bench at the negedge right after the sampling edge (j = 0)
  task automatic pulseEnd(input int g, input int off);
    guardBits = 8'(g); phaseOffset = 8'(off); txEnd = 1'b1;
    @(negedge clk); txEnd = 1'b0;
  endtask

  task automatic pulseStart();
    txStart = 1'b1;
    @(negedge clk); txStart = 1'b0;
  endtask

  task automatic stepTo(inout int j, input int target);
    while (j < target) begin @(negedge clk); j++; end
  endtask

  initial begin
    int j;
    @(negedge clk);
    chk("R1 reset rxEnable", rxEnable, 1'b0);
    chk("R1 reset bitStrobe", bitStrobe, 1'b0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (300) @(negedge clk);
    chk("R1 idle rxEnable", rxEnable, 1'b0);

    // zero guard, offset 0
    pulseEnd(0, 0); j = 0;
    chk("R3 enable at end edge", rxEnable, 1'b1);
    chk("R6 bit strobe at phase 0", bitStrobe, 1'b1);
    stepTo(j, 64);
    chk("R7 half strobe at 64", halfStrobe, 1'b1);
    stepTo(j, 128);
    chk("R6 bit strobe period", bitStrobe, 1'b1);

    // stop
    pulseStart();
    chk("R4 start drops enable", rxEnable, 1'b0);
    repeat (200) @(negedge clk);
    chk("R4 still off", rxEnable, 1'b0);

    // guard 2, offset 200 -> 72, settings changed afterwards
    pulseEnd(2, 200); j = 0;
    guardBits = 8'd5; phaseOffset = 8'd3;
    stepTo(j, 72);
    chk("R5 no strobe in guard", bitStrobe, 1'b0);
    stepTo(j, 255);
    chk("R2 still off before 256", rxEnable, 1'b0);
    stepTo(j, 256);
    chk("R2 on at 256", rxEnable, 1'b1);
    chk("R9 guard latched", rxEnable, 1'b1);
    stepTo(j, 264);
    chk("R7 half strobe at phase 8", halfStrobe, 1'b1);
    stepTo(j, 327);
    chk("R8 no bit strobe before 72", bitStrobe, 1'b0);
    stepTo(j, 328);
    chk("R8 bit strobe at phase 72", bitStrobe, 1'b1);
    stepTo(j, 456);
    chk("R6 next bit strobe", bitStrobe, 1'b1);

    // restart while receiving
    @(negedge clk);
    pulseEnd(1, 10); j = 0;
    chk("R10 restart drops enable", rxEnable, 1'b0);
    stepTo(j, 127);
    chk("R10 off at 127", rxEnable, 1'b0);
    stepTo(j, 128);
    chk("R10 on at 128", rxEnable, 1'b1);
    stepTo(j, 138);
    chk("R10 bit strobe new offset", bitStrobe, 1'b1);

    // start and end together
    txStart = 1'b1; txEnd = 1'b1; guardBits = 8'd0;
    @(negedge clk); txStart = 1'b0; txEnd = 1'b0;
    chk("R4 start wins over end", rxEnable, 1'b0);
    repeat (20) @(negedge clk);
    chk("R4 no strobe after tie", bitStrobe | halfStrobe, 1'b0);

    // start during guard
    pulseEnd(3, 0);
    repeat (50) @(negedge clk);
    pulseStart();
    repeat (450) @(negedge clk);
    chk("R4 guard abandoned", rxEnable, 1'b0);

    // a sweep of offsets
    for (int k = 0; k < 6; k++) begin
      pulseEnd(k % 2, k * 53 + 17);
      repeat (300) @(negedge clk);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule